// File: doc/BRIEF.md
# Bit-Serial Two-Register Adder

This block adds two 8-bit operands one bit per clock. Two shift registers are loaded in parallel from separate input buses. Register B rotates: its outgoing bit goes straight back into its top end, so after eight shifts it again holds its operand. Register A takes its serial input from a one-bit adder stage. That stage combines the low bits of both registers with a carry it keeps in a flip-flop. The sum bit is registered before it enters A, so A needs one more shift clock than B.

Each register has its own 2-bit mode control, so the two can shift for different numbers of clocks. A complete addition takes one load clock, eight clocks with both registers shifting, and one more clock with only A shifting. After that, A holds the 8-bit sum, B holds its original operand, and the carry output shows whether the result overflowed 8 bits.

Top module: `sadd_serial_top`

## Requirements
- R1: A synchronous active-low reset clears register A, register B, the registered sum bit and the carry on the rising clock edge.
- R2: Mode code 3 on a register's mode input loads that register from its own input bus on the next rising edge.
- R3: Mode codes 0 and 1 leave a register's contents unchanged.
- R4: Mode code 2 shifts a register right by one bit per clock. In register B, the bit leaving position 0 enters position 7.
- R5: While register A shifts, position 7 receives the sum bit that the adder stage registered on the previous clock.
- R6: The adder stage updates only on clocks where both registers are in mode 2. On such a clock, the carry becomes the majority of A[0], B[0] and the old carry, and the sum bit becomes their exclusive-or.
- R7: The sum bit and the carry clear whenever either register is in mode 3, so each addition starts with a carry-in of zero.
- R8: After both registers load, shift together for 8 clocks, and then A alone shifts 1 more clock, A holds (a+b) mod 256 and B holds b. For example, loading 0x3F and 0x3B gives 0x7A and 0x3B.
- R9: The carry output shows bit 8 of a+b after the addition, and it holds while neither register loads and the two registers are not both shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_a | input | 8 | Parallel load value for register A |
| din_b | input | 8 | Parallel load value for register B |
| mode_a | input | 2 | Register A control: 0/1 hold, 2 shift, 3 load |
| mode_b | input | 2 | Register B control: 0/1 hold, 2 shift, 3 load |
| reg_a | output | 8 | Register A contents (the sum after an addition) |
| reg_b | output | 8 | Register B contents |
| carry_out | output | 1 | Registered carry of the adder stage |

## Verification
The assertions check the per-clock rules on every cycle:
- loading and holding of each register;
- the right shift, including B's rotate bit and A's top bit taken from the registered sum;
- the carry clearing on any load;
- the carry holding when the adder stage is idle, and its majority rule when it runs.

Only the bench's scenarios can show the end-to-end results. These are that nine shifts of A against eight of B leave the correct sum and restore B, and that an overflowing pair leaves carry_out set until the next load. A behavioural model compares all outputs after every clock.

// File: rtl/sadd_pkg.sv
// Package: shared mode encoding for the bit-serial adder.
// Assumes: 2-bit mode fields; code 1 is a spare hold code.
package sadd_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_SPARE = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_LOAD  = 2'd3
    } sadd_mode_e;
endpackage

// File: rtl/sadd_shift_reg.sv
// Module: parallel-load right-shift register with a serial input at the MSB.
// Assumes: synchronous active-low reset; mode per sadd_pkg encoding.
module sadd_shift_reg
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    input  logic         ser_in,
    output logic [W-1:0] q,
    output logic         lsb
);
    sadd_mode_e mode_e;
    logic [W-1:0] q_next;

    // Purpose: decode the raw mode field.
    assign mode_e = sadd_mode_e'(mode);

    // Purpose: select the next register value for the mode.
    always_comb begin
        case (mode_e)
            MODE_LOAD:  q_next = din;
            MODE_SHIFT: q_next = {ser_in, q[W-1:1]};
            default:    q_next = q;
        endcase
    end

    // Purpose: register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // Purpose: expose the outgoing bit.
    assign lsb = q[0];

    AST_LOAD_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (q == $past(din))); // R2
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || mode == 2'd1) |=> $stable(q)); // R3
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> (q[W-2:0] == $past(q[W-1:1]))); // R4
endmodule

// File: rtl/sadd_bit_stage.sv
// Module: one-bit full adder with registered sum and carry.
// Assumes: clr has priority over en; en is asserted only when both operands advance.
module sadd_bit_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_q,
    output logic carry_q
);
    logic sum_c;
    logic carry_c;

    // Purpose: combinational full-adder bit.
    always_comb begin
        sum_c   = a_bit ^ b_bit ^ carry_q;
        carry_c = (a_bit & b_bit) | (a_bit & carry_q) | (b_bit & carry_q);
    end

    // Purpose: capture sum and carry; clear on load or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else if (en) begin
            sum_q   <= sum_c;
            carry_q <= carry_c;
        end
    end

    AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!carry_q && !sum_q)); // R7
    AST_CARRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> ($stable(carry_q) && $stable(sum_q))); // R9
    AST_CARRY_MAJ: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && en) |=> (carry_q == ($countones({$past(a_bit), $past(b_bit), $past(carry_q)}) >= 2))); // R6
endmodule

// File: rtl/sadd_serial_top.sv
// Module: bit-serial adder; A accumulates the sum, B rotates back to its operand.
// Assumes: operands of W bits; the caller shifts B W clocks and A W+1 clocks.
module sadd_serial_top #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_a,
    input  logic [W-1:0] din_b,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic         carry_out
);
    localparam logic [1:0] CODE_SHIFT = 2'd2;
    localparam logic [1:0] CODE_LOAD  = 2'd3;

    logic a_lsb;
    logic b_lsb;
    logic sum_bit;
    logic stage_clr;
    logic stage_en;

    // Purpose: control of the adder stage from both modes.
    assign stage_clr = (mode_a == CODE_LOAD) || (mode_b == CODE_LOAD);
    assign stage_en  = (mode_a == CODE_SHIFT) && (mode_b == CODE_SHIFT);

    sadd_shift_reg #(.W(W)) u_reg_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_a),
        .din    (din_a),
        .ser_in (sum_bit),
        .q      (reg_a),
        .lsb    (a_lsb)
    );

    sadd_shift_reg #(.W(W)) u_reg_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_b),
        .din    (din_b),
        .ser_in (b_lsb),
        .q      (reg_b),
        .lsb    (b_lsb)
    );

    sadd_bit_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stage_clr),
        .en      (stage_en),
        .a_bit   (a_lsb),
        .b_bit   (b_lsb),
        .sum_q   (sum_bit),
        .carry_q (carry_out)
    );

    AST_B_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b == CODE_SHIFT) |=> (reg_b[W-1] == $past(reg_b[0]))); // R4
    AST_A_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a == CODE_SHIFT) |=> (reg_a[W-1] == $past(sum_bit))); // R5
endmodule

// File: tb/sadd_serial_top_tb.sv
`timescale 1ns/100ps
module sadd_serial_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din_a = '0;
    logic [7:0] din_b = '0;
    logic [1:0] mode_a = '0;
    logic [1:0] mode_b = '0;
    logic [7:0] reg_a;
    logic [7:0] reg_b;
    logic       carry_out;

    int total = 0;
    int bad = 0;
    int m_a = 0, m_b = 0, m_sum = 0, m_cy = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sadd_serial_top u_dut (
        .clk(clk), .rst_n(rst_n), .din_a(din_a), .din_b(din_b),
        .mode_a(mode_a), .mode_b(mode_b),
        .reg_a(reg_a), .reg_b(reg_b), .carry_out(carry_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: arithmetic on integers.
    always @(posedge clk) begin
        int t;
        if (!rst_n) begin
            m_a <= 0; m_b <= 0; m_sum <= 0; m_cy <= 0;
        end else begin
            if (mode_a == 3) m_a <= din_a;
            else if (mode_a == 2) m_a <= (m_a / 2) + m_sum * 128;
            if (mode_b == 3) m_b <= din_b;
            else if (mode_b == 2) m_b <= (m_b / 2) + (m_b % 2) * 128;
            if (mode_a == 3 || mode_b == 3) begin
                m_sum <= 0; m_cy <= 0;
            end else if (mode_a == 2 && mode_b == 2) begin
                t = (m_a % 2) + (m_b % 2) + m_cy;
                m_sum <= t % 2;
                m_cy  <= t / 2;
            end
        end
    end

    // Per-clock comparison against the model.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check("R5 reg_a", reg_a, m_a);
            check("R4 reg_b", reg_b, m_b);
            check("R6 carry", carry_out, m_cy);
        end
    end

    task automatic step(input logic [1:0] ma, input logic [1:0] mb);
        @(negedge clk);
        mode_a = ma;
        mode_b = mb;
    endtask

    task automatic run_add(input int a, input int b);
        @(negedge clk);
        din_a = 8'(a); din_b = 8'(b);
        mode_a = 2'd3; mode_b = 2'd3;
        for (int i = 0; i < 8; i++) step(2'd2, 2'd2);
        step(2'd2, 2'd0);
        step(2'd0, 2'd0);
        @(posedge clk); #2;
        check("R8 sum", reg_a, (a + b) % 256);
        check("R8 b restored", reg_b, b);
        check("R9 carry", carry_out, (a + b) / 256);
    endtask

    initial begin
        #(5.0 * 200000);
        $display("FAIL watchdog actual=running expected=finished");
        bad++; total++;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset a", reg_a, 0);
        check("R1 reset b", reg_b, 0);
        check("R1 reset carry", carry_out, 0);
        rst_n = 1'b1;
        run_add(8'h3F, 8'h3B);
        run_add(8'hFF, 8'h01);
        // R9: carry stays set while held
        step(2'd1, 2'd0);
        step(2'd0, 2'd1);
        @(posedge clk); #2;
        check("R9 carry held", carry_out, 1);
        check("R3 spare hold a", reg_a, 0);
        // R7: loading A alone clears the carry
        @(negedge clk); din_a = 8'h55; mode_a = 2'd3; mode_b = 2'd0;
        step(2'd0, 2'd0);
        @(posedge clk); #2;
        check("R7 clear", carry_out, 0);
        check("R2 load a", reg_a, 8'h55);
        check("R3 hold b", reg_b, 8'h01);
        run_add(8'hA5, 8'h5B);
        run_add(8'h80, 8'h80);
        run_add(8'h00, 8'h00);
        run_add(8'h12, 8'h34);
        // R1 mid-shift reset
        @(negedge clk); din_a = 8'hC3; din_b = 8'h3C; mode_a = 2'd3; mode_b = 2'd3;
        step(2'd2, 2'd2);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        check("R1 reset a", reg_a, 0);
        check("R1 reset b", reg_b, 0);
        @(negedge clk); rst_n = 1'b1; mode_a = 2'd0; mode_b = 2'd0;
        repeat (2) @(posedge clk);
        #2.2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule